// File: doc/BRIEF.md
# Page-Mode DRAM Controller with Refresh Arbitration

This block sits between a simple processor request port and a DRAM device whose address pins carry the row and the column one after the other. Each accepted request is split into a row half and a column half. The row half is placed on the shared address pins while the row strobe falls. After a programmable row delay, the column half is placed on the same pins under the column strobe. The row stays open after the access. A following request to that same row then needs only a fresh column phase. A request to another row closes the page, waits out a precharge gap, and opens the new row.

A refresh timer raises one refresh request per interval. The interval is meant to be the retention time divided by the number of rows. Refresh outranks processor traffic. The access in flight finishes first. The open page is then closed, and a row-strobe-only cycle is run at the address held in an internal row counter. That counter advances by one after each refresh and wraps after the last row. If a second interval expires while a refresh is still waiting, a sticky overrun flag is set. All timing is counted in clock cycles fixed by parameters.

Top module: `pagemode_dram_ctrl`

## Requirements
- R1: While reset is held, the row, column and write strobes (active low) are all high, `cpu_ready` is high, `cpu_rvalid` is low and `ref_overrun` is low.
- R2: `cpu_addr` is split into a row (upper `ROW_BITS`) and a column (lower `COL_BITS`). The row appears on `dram_addr` in the cycle the row strobe falls, and the column appears on `dram_addr` while the column strobe is low. Data written to an address is returned by a later read of that address.
- R3: The row strobe is low for at least `T_ROW` cycles before the column strobe falls.
- R4: The column strobe is low only while the row strobe is low, and it stays low for exactly `T_COL` cycles per access. The write strobe is low during the column phase of a write and high during the column phase of a read.
- R5: A read returns its data on `cpu_rdata` with a one-cycle `cpu_rvalid` pulse, in the first cycle after the last column-strobe cycle.
- R6: A request whose row equals the open row, with no refresh since the previous access, causes no new fall of the row strobe.
- R7: After every rise of the row strobe, the strobe stays high for at least `T_PRE` cycles before it falls again. A request to a different row produces exactly one new row-strobe fall.
- R8: One refresh is requested every `REF_INTERVAL` cycles. Each refresh holds the row strobe low for exactly `T_ROW` cycles with no column strobe.
- R9: The refresh row counter starts at 0 after reset and advances by one, modulo 2^`ROW_BITS`, after each refresh.
- R10: A pending refresh outranks processor requests. `cpu_ready` is low while a refresh is pending or running, and also while an access or a row change is in progress.
- R11: `ref_overrun` goes high, and stays high until reset, when the refresh interval expires again while the previous refresh is still pending. It stays low when refreshes keep pace.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_valid | input | 1 | Request present |
| cpu_ready | output | 1 | Request accepted on a cycle where both valid and ready are high |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ROW_BITS+COL_BITS | Word address, row bits above column bits |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data |
| cpu_rvalid | output | 1 | One-cycle read data valid pulse |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_addr | output | max(ROW_BITS,COL_BITS) | Multiplexed row/column address |
| dram_wdata | output | DATA_W | Data to the device |
| dram_rdata | input | DATA_W | Data from the device |
| ref_overrun | output | 1 | Sticky refresh overrun flag |

## Verification
The main instance uses 3 row bits, 4 column bits, a 5-cycle row phase, a 2-cycle column phase, a 3-cycle precharge and a 40-cycle refresh interval. With only eight rows, the refresh counter wraps several times in one run. Random traffic drawn from few rows produces frequent page hits and row changes, and multi-cycle column phases expose miscounted strobe widths. A second instance has a 4-cycle interval, shorter than one refresh cycle, so the overrun flag becomes reachable.

// File: rtl/dramc_pkg.sv
package dramc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACT,
        ST_COL,
        ST_OPEN,
        ST_PRE,
        ST_REF
    } seq_state_e;

    typedef enum logic [1:0] {
        PIN_ROW,
        PIN_COL,
        PIN_REFROW
    } pin_sel_e;

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int cnt_bits(int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/dramc_refresh_timer.sv
module dramc_refresh_timer #(
    parameter int REF_INTERVAL = 390,
    parameter int ROW_BITS     = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ref_ack,
    input  logic                ref_done,
    output logic                ref_pend,
    output logic [ROW_BITS-1:0] ref_row,
    output logic                ref_overrun
);
    import dramc_pkg::*;

    localparam int TW = cnt_bits(REF_INTERVAL);
    localparam logic [TW-1:0] LAST = TW'(REF_INTERVAL - 1);

    logic [TW-1:0] tcnt;
    logic          tick;

    assign tick = (tcnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            tcnt <= '0;
        end else if (tick) begin
            tcnt <= '0;
        end else begin
            tcnt <= tcnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_pend    <= 1'b0;
            ref_overrun <= 1'b0;
        end else if (tick) begin
            ref_pend <= 1'b1;
            if (ref_pend && !ref_ack) begin
                ref_overrun <= 1'b1;
            end
        end else if (ref_ack) begin
            ref_pend <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_row <= '0;
        end else if (ref_done) begin
            ref_row <= ref_row + 1'b1;
        end
    end

endmodule

// File: rtl/dramc_addr_mux.sv
module dramc_addr_mux #(
    parameter int ROW_BITS = 8,
    parameter int COL_BITS = 8,
    parameter int PIN_W    = 8
) (
    input  dramc_pkg::pin_sel_e  sel,
    input  logic [ROW_BITS-1:0]  row,
    input  logic [COL_BITS-1:0]  col,
    input  logic [ROW_BITS-1:0]  ref_row,
    output logic [PIN_W-1:0]     pins
);
    import dramc_pkg::*;

    logic [PIN_W-1:0] row_w;
    logic [PIN_W-1:0] col_w;
    logic [PIN_W-1:0] ref_w;

    generate
        if (PIN_W > ROW_BITS) begin : g_row_pad
            assign row_w = {{(PIN_W-ROW_BITS){1'b0}}, row};
            assign ref_w = {{(PIN_W-ROW_BITS){1'b0}}, ref_row};
        end else begin : g_row_full
            assign row_w = row;
            assign ref_w = ref_row;
        end
        if (PIN_W > COL_BITS) begin : g_col_pad
            assign col_w = {{(PIN_W-COL_BITS){1'b0}}, col};
        end else begin : g_col_full
            assign col_w = col;
        end
    endgenerate

    always_comb begin
        case (sel)
            PIN_COL:    pins = col_w;
            PIN_REFROW: pins = ref_w;
            default:    pins = row_w;
        endcase
    end

endmodule

// File: rtl/dramc_seq.sv
module dramc_seq #(
    parameter int ROW_BITS = 8,
    parameter int COL_BITS = 8,
    parameter int DATA_W   = 16,
    parameter int T_ROW    = 4,
    parameter int T_COL    = 1,
    parameter int T_PRE    = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cpu_valid,
    input  logic                     cpu_write,
    input  logic [ROW_BITS-1:0]      cpu_row,
    input  logic [COL_BITS-1:0]      cpu_col,
    input  logic [DATA_W-1:0]        cpu_wdata,
    output logic                     cpu_ready,
    output logic [DATA_W-1:0]        cpu_rdata,
    output logic                     cpu_rvalid,
    input  logic                     ref_pend,
    output logic                     ref_ack,
    output logic                     ref_done,
    output logic                     ras_n,
    output logic                     cas_n,
    output logic                     we_n,
    output dramc_pkg::pin_sel_e      pin_sel,
    output logic [ROW_BITS-1:0]      open_row,
    output logic [COL_BITS-1:0]      act_col,
    output logic [DATA_W-1:0]        act_wdata,
    input  logic [DATA_W-1:0]        dram_rdata,
    output dramc_pkg::seq_state_e    st
);
    import dramc_pkg::*;

    localparam int CW = cnt_bits(max3(T_ROW, T_COL, T_PRE)) + 1;
    localparam logic [CW-1:0] LD_ROW = CW'(T_ROW - 1);
    localparam logic [CW-1:0] LD_COL = CW'(T_COL - 1);
    localparam logic [CW-1:0] LD_PRE = CW'(T_PRE - 1);

    logic [CW-1:0] cnt;
    logic          act_we;
    logic          have_req;
    logic          accept;
    logic          hit;
    logic          cnt_end;

    assign cpu_ready = ((st == ST_IDLE) || (st == ST_OPEN)) && !ref_pend;
    assign accept    = cpu_valid && cpu_ready;
    assign hit       = (cpu_row == open_row);
    assign cnt_end   = (cnt == '0);
    assign ref_ack   = (st == ST_IDLE) && ref_pend;
    assign ref_done  = (st == ST_REF) && cnt_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            cnt        <= '0;
            open_row   <= '0;
            act_col    <= '0;
            act_wdata  <= '0;
            act_we     <= 1'b0;
            have_req   <= 1'b0;
            cpu_rvalid <= 1'b0;
            cpu_rdata  <= '0;
        end else begin
            cpu_rvalid <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (ref_pend) begin
                        st  <= ST_REF;
                        cnt <= LD_ROW;
                    end else if (accept) begin
                        act_col   <= cpu_col;
                        act_wdata <= cpu_wdata;
                        act_we    <= cpu_write;
                        open_row  <= cpu_row;
                        st        <= ST_ACT;
                        cnt       <= LD_ROW;
                    end
                end
                ST_OPEN: begin
                    if (ref_pend) begin
                        st       <= ST_PRE;
                        cnt      <= LD_PRE;
                        have_req <= 1'b0;
                    end else if (accept) begin
                        act_col   <= cpu_col;
                        act_wdata <= cpu_wdata;
                        act_we    <= cpu_write;
                        if (hit) begin
                            st  <= ST_COL;
                            cnt <= LD_COL;
                        end else begin
                            open_row <= cpu_row;
                            have_req <= 1'b1;
                            st       <= ST_PRE;
                            cnt      <= LD_PRE;
                        end
                    end
                end
                ST_ACT: begin
                    if (cnt_end) begin
                        st  <= ST_COL;
                        cnt <= LD_COL;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_COL: begin
                    if (cnt_end) begin
                        st <= ST_OPEN;
                        if (!act_we) begin
                            cpu_rvalid <= 1'b1;
                            cpu_rdata  <= dram_rdata;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_PRE: begin
                    if (cnt_end) begin
                        if (have_req) begin
                            have_req <= 1'b0;
                            st       <= ST_ACT;
                            cnt      <= LD_ROW;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_REF: begin
                    if (cnt_end) begin
                        st       <= ST_PRE;
                        cnt      <= LD_PRE;
                        have_req <= 1'b0;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    st <= ST_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        ras_n   = !((st == ST_ACT) || (st == ST_COL) || (st == ST_OPEN) || (st == ST_REF));
        cas_n   = !(st == ST_COL);
        we_n    = !((st == ST_COL) && act_we);
        case (st)
            ST_COL:  pin_sel = PIN_COL;
            ST_REF:  pin_sel = PIN_REFROW;
            default: pin_sel = PIN_ROW;
        endcase
    end

endmodule

// File: rtl/pagemode_dram_ctrl.sv
module pagemode_dram_ctrl #(
    parameter int ROW_BITS     = 8,
    parameter int COL_BITS     = 8,
    parameter int DATA_W       = 16,
    parameter int T_ROW        = 4,
    parameter int T_COL        = 1,
    parameter int T_PRE        = 2,
    parameter int REF_INTERVAL = 390,
    localparam int ADDR_W      = ROW_BITS + COL_BITS,
    localparam int PIN_W       = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    output logic              cpu_ready,
    input  logic              cpu_write,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_rvalid,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic [PIN_W-1:0]  dram_addr,
    output logic [DATA_W-1:0] dram_wdata,
    input  logic [DATA_W-1:0] dram_rdata,
    output logic              ref_overrun
);
    import dramc_pkg::*;

    logic                ref_pend;
    logic                ref_ack;
    logic                ref_done;
    logic [ROW_BITS-1:0] ref_row;
    logic [ROW_BITS-1:0] open_row;
    logic [COL_BITS-1:0] act_col;
    pin_sel_e            pin_sel;
    seq_state_e          st;

    dramc_refresh_timer #(
        .REF_INTERVAL (REF_INTERVAL),
        .ROW_BITS     (ROW_BITS)
    ) u_timer (
        .clk         (clk),
        .rst         (rst),
        .ref_ack     (ref_ack),
        .ref_done    (ref_done),
        .ref_pend    (ref_pend),
        .ref_row     (ref_row),
        .ref_overrun (ref_overrun)
    );

    dramc_seq #(
        .ROW_BITS (ROW_BITS),
        .COL_BITS (COL_BITS),
        .DATA_W   (DATA_W),
        .T_ROW    (T_ROW),
        .T_COL    (T_COL),
        .T_PRE    (T_PRE)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cpu_valid  (cpu_valid),
        .cpu_write  (cpu_write),
        .cpu_row    (cpu_addr[ADDR_W-1:COL_BITS]),
        .cpu_col    (cpu_addr[COL_BITS-1:0]),
        .cpu_wdata  (cpu_wdata),
        .cpu_ready  (cpu_ready),
        .cpu_rdata  (cpu_rdata),
        .cpu_rvalid (cpu_rvalid),
        .ref_pend   (ref_pend),
        .ref_ack    (ref_ack),
        .ref_done   (ref_done),
        .ras_n      (dram_ras_n),
        .cas_n      (dram_cas_n),
        .we_n       (dram_we_n),
        .pin_sel    (pin_sel),
        .open_row   (open_row),
        .act_col    (act_col),
        .act_wdata  (dram_wdata),
        .dram_rdata (dram_rdata),
        .st         (st)
    );

    dramc_addr_mux #(
        .ROW_BITS (ROW_BITS),
        .COL_BITS (COL_BITS),
        .PIN_W    (PIN_W)
    ) u_mux (
        .sel     (pin_sel),
        .row     (open_row),
        .col     (act_col),
        .ref_row (ref_row),
        .pins    (dram_addr)
    );

endmodule

// File: rtl/dramc_checker.sv
module dramc_checker #(
    parameter int ROW_BITS = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                ras_n,
    input logic                cas_n,
    input logic                we_n,
    input logic                ready,
    input logic                rvalid,
    input logic                overrun,
    input logic                pend,
    input logic                in_ref,
    input logic [ROW_BITS-1:0] ref_row
);

    // R3: column strobe falls only after the row strobe was already low
    a_r3_ras_before_cas: assert property (@(posedge clk) disable iff (rst)
        $fell(cas_n) |-> $past(!ras_n));

    // R4
    a_r4_cas_within_ras: assert property (@(posedge clk) disable iff (rst)
        !cas_n |-> !ras_n);

    a_r4_we_within_cas: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> !cas_n);

    // R5
    a_r5_rvalid_after_cas: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> (cas_n && $past(!cas_n)));

    // R8
    a_r8_refresh_ras_only: assert property (@(posedge clk) disable iff (rst)
        in_ref |-> (!ras_n && cas_n));

    // R9
    a_r9_ref_row_steps: assert property (@(posedge clk) disable iff (rst)
        (ref_row != $past(ref_row)) |-> (ref_row == ROW_BITS'($past(ref_row) + 1'b1)));

    // R10
    a_r10_refresh_blocks_cpu: assert property (@(posedge clk) disable iff (rst)
        (pend || in_ref) |-> !ready);

    // R11
    a_r11_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

endmodule

bind pagemode_dram_ctrl dramc_checker #(.ROW_BITS(ROW_BITS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ras_n   (dram_ras_n),
    .cas_n   (dram_cas_n),
    .we_n    (dram_we_n),
    .ready   (cpu_ready),
    .rvalid  (cpu_rvalid),
    .overrun (ref_overrun),
    .pend    (ref_pend),
    .in_ref  (st == dramc_pkg::ST_REF),
    .ref_row (ref_row)
);

// File: tb/tb_pagemode_dram_ctrl.sv
module tb_pagemode_dram_ctrl;

    localparam int RB = 3;
    localparam int CB = 4;
    localparam int DW = 8;
    localparam int TR = 5;
    localparam int TC = 2;
    localparam int TP = 3;
    localparam int RI = 40;
    localparam int PW = 4;
    localparam int NW = 1 << (RB + CB);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          valid = 1'b0;
    logic          wr = 1'b0;
    logic [RB+CB-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          ready, rvalid, ras_n, cas_n, we_n, ovr;
    logic [DW-1:0] rdata, dwdata, drdata;
    logic [PW-1:0] daddr;

    logic          f_ready, f_rvalid, f_ras, f_cas, f_we, f_ovr;
    logic [DW-1:0] f_rdata, f_wdata;
    logic [PW-1:0] f_addr;

    always #10 clk = ~clk;

    logic [DW-1:0] model_mem [NW];
    logic [DW-1:0] ref_mem   [NW];
    logic [RB-1:0] lat_row = '0;

    assign drdata = model_mem[{lat_row, daddr[CB-1:0]}];

    pagemode_dram_ctrl #(.ROW_BITS(RB), .COL_BITS(CB), .DATA_W(DW), .T_ROW(TR),
        .T_COL(TC), .T_PRE(TP), .REF_INTERVAL(RI)) dut (
        .clk(clk), .rst(rst), .cpu_valid(valid), .cpu_ready(ready), .cpu_write(wr),
        .cpu_addr(addr), .cpu_wdata(wdata), .cpu_rdata(rdata), .cpu_rvalid(rvalid),
        .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_addr(daddr),
        .dram_wdata(dwdata), .dram_rdata(drdata), .ref_overrun(ovr));

    pagemode_dram_ctrl #(.ROW_BITS(RB), .COL_BITS(CB), .DATA_W(DW), .T_ROW(TR),
        .T_COL(TC), .T_PRE(TP), .REF_INTERVAL(4)) dut_fast (
        .clk(clk), .rst(rst), .cpu_valid(1'b0), .cpu_ready(f_ready), .cpu_write(1'b0),
        .cpu_addr('0), .cpu_wdata('0), .cpu_rdata(f_rdata), .cpu_rvalid(f_rvalid),
        .dram_ras_n(f_ras), .dram_cas_n(f_cas), .dram_we_n(f_we), .dram_addr(f_addr),
        .dram_wdata(f_wdata), .dram_rdata('0), .ref_overrun(f_ovr));

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] exp_read(input logic [RB-1:0] r, input logic [CB-1:0] c);
        return ref_mem[{r, c}];
    endfunction

    // Pin monitor and device model
    int  ras_falls = 0;
    int  refreshes = 0;
    int  cycles = 0;
    int  low_cnt = 0;
    int  high_cnt = 100;
    int  cas_cnt = 0;
    bit  saw_cas = 0;
    bit  ready_in_win = 0;
    bit  prev_ras = 1, prev_cas = 1;
    bit  cur_write = 0;
    logic [RB-1:0] exp_ref_row = '0;

    always @(negedge clk) begin
        if (!rst) begin
            cycles++;
            if (prev_ras && !ras_n) begin
                ras_falls++;
                chk(high_cnt >= TP, "R7 precharge gap", high_cnt, TP);
                lat_row = daddr[RB-1:0];
                low_cnt = 1;
                saw_cas = 0;
                ready_in_win = ready;
            end else if (!ras_n) begin
                if (!saw_cas && cas_n) low_cnt++;
                if (ready) ready_in_win = 1;
            end
            if (!prev_ras && ras_n) begin
                if (!saw_cas) begin
                    refreshes++;
                    chk(lat_row == exp_ref_row, "R9 refresh row", lat_row, exp_ref_row);
                    chk(low_cnt == TR, "R8 refresh width", low_cnt, TR);
                    chk(!ready_in_win, "R10 ready during refresh", ready_in_win, 0);
                    exp_ref_row = exp_ref_row + 1'b1;
                end
                high_cnt = 1;
            end else if (ras_n) begin
                high_cnt++;
            end
            if (!cas_n) begin
                chk(!ras_n, "R4 cas inside ras", ras_n, 0);
                if (!saw_cas) chk(low_cnt >= TR, "R3 ras-to-cas", low_cnt, TR);
                saw_cas = 1;
                cas_cnt++;
                chk(we_n == !cur_write, "R4 write strobe", we_n, !cur_write);
                if (!we_n) model_mem[{lat_row, daddr[CB-1:0]}] = dwdata;
            end else if (!prev_cas) begin
                chk(cas_cnt == TC, "R4 column width", cas_cnt, TC);
                cas_cnt = 0;
            end
            if (rvalid) chk(!prev_cas && cas_n, "R5 rvalid timing", prev_cas, 0);
            prev_ras = ras_n;
            prev_cas = cas_n;
        end
    end

    int last_refs = -1;
    logic [RB-1:0] last_row = '0;

    task automatic do_op(input bit w, input logic [RB-1:0] r, input logic [CB-1:0] c,
                         input logic [DW-1:0] d);
        int falls0, refs0;
        bit saw_low;
        falls0 = ras_falls;
        refs0  = refreshes;
        @(negedge clk);
        valid = 1'b1; wr = w; addr = {r, c}; wdata = d; cur_write = w;
        while (!ready) @(negedge clk);
        @(negedge clk);
        valid = 1'b0;
        saw_low = !cas_n;
        while (!(saw_low && cas_n)) begin
            @(negedge clk);
            if (!cas_n) saw_low = 1;
        end
        if (w) begin
            ref_mem[{r, c}] = d;
        end else begin
            chk(rvalid == 1'b1, "R5 rvalid pulse", rvalid, 1);
            chk(rdata == exp_read(r, c), "R2 read data", rdata, exp_read(r, c));
        end
        if (r == last_row && last_refs == refreshes)
            chk(ras_falls == falls0, "R6 page hit, no new row", ras_falls - falls0, 0);
        else if (r != last_row && refreshes == refs0 && last_refs == refs0)
            chk(ras_falls == falls0 + 1, "R7 row change", ras_falls - falls0, 1);
        last_row = r;
        last_refs = refreshes;
    endtask

    function automatic void summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endfunction

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1bad5eed));
        for (int i = 0; i < NW; i++) begin
            model_mem[i] = '0;
            ref_mem[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ras_n && cas_n && we_n, "R1 strobes idle", {ras_n, cas_n, we_n}, 7);
        chk(ready == 1'b1, "R1 ready", ready, 1);
        chk(rvalid == 1'b0, "R1 rvalid", rvalid, 0);
        chk(ovr == 1'b0 && f_ovr == 1'b0, "R1 overrun", ovr, 0);
        rst = 1'b0;

        // directed corners
        do_op(1, 3'd2, 4'd3, 8'hA5);
        do_op(0, 3'd2, 4'd3, 8'h00);   // R6 page hit read
        do_op(1, 3'd2, 4'd15, 8'h3C);  // R6 page hit write
        do_op(0, 3'd2, 4'd15, 8'h00);
        do_op(0, 3'd5, 4'd0, 8'h00);   // R7 row change, unwritten reads 0
        do_op(0, 3'd2, 4'd3, 8'h00);
        do_op(1, 3'd7, 4'd15, 8'hFF);  // top corner
        do_op(0, 3'd7, 4'd15, 8'h00);

        for (int k = 0; k < 400; k++) begin
            logic [RB-1:0] r;
            r = ($urandom_range(0, 1) == 0) ? last_row : RB'($urandom_range(0, 3));
            do_op(bit'($urandom_range(0, 1)), r, CB'($urandom()), DW'($urandom()));
        end
        for (int a = 0; a < 16; a++) do_op(0, 3'd2, CB'(a), 8'h00);

        repeat (100) @(negedge clk);
        // R8 refresh rate under traffic and at rest
        chk(refreshes <= cycles / RI && refreshes >= cycles / RI - 2,
            "R8 refresh count", refreshes, cycles / RI);
        chk(refreshes > (1 << RB), "R9 counter wrapped", refreshes, 1 << RB);
        chk(ovr == 1'b0, "R11 no overrun when keeping pace", ovr, 0);
        chk(f_ovr == 1'b1, "R11 overrun on short interval", f_ovr, 1);
        finished = 1;
        summary();
        $finish;
    end

endmodule